// File: doc/BRIEF.md
# TLB Global Invalidate Walker

This block carries out one broadcast invalidation request against a translation table held outside the block. A request names one of four invalidation kinds, a virtual address with a 2-bit region tag, an address-space identifier (MMID) and the boundary of the wired entries. After it accepts the request, the walker reads every table entry in index order through a read port. For each entry it decides whether the entry must die. It then writes the entry back through a write port. A dead entry is written back with its invalidated flag (EHINV) set and every other bit unchanged. A live entry is written back exactly as it was read.

The request side is a valid/ready stream of one beat per operation. `req_ready` is high only while the walker is idle. The requester holds `req_valid` and its fields until it sees `req_ready`. The block never buffers a second request, so a `req_valid` raised during a walk has no effect. Busy and the flush-done pulse are plain status pins. A downstream translation cache uses the one-cycle `flush_done` pulse to drop its own copies once the walk has finished.

Top module: `tlbinv_engine`

## Requirements
- R1: `req_ready` equals `!busy`. A request is taken on a clock edge where `req_valid && req_ready` is true. The kind, VPN2, region, MMID and wired value are captured at that edge. `req_valid` while busy is ignored: it neither starts a second walk nor changes the walk in progress.
- R2: In the cycle after acceptance `busy` and `rd_en` are high and `rd_addr` is 0. Each following cycle reads the next index, up to ENTRIES-1. The read data arrives one cycle after its address, and that entry is written (`wr_en`, `wr_addr`) in the same cycle the data arrives. `busy` stays high until the last write, ENTRIES+1 cycles in all.
- R3: `flush_done` is high for exactly one cycle, the cycle after the write of entry ENTRIES-1, and `busy` is already low in that cycle.
- R4: Entry layout, LSB first: payload [PAY_W-1:0], EHINV at bit PAY_W, global bit at PAY_W+1, MMID (MMID_W bits), page mask (VPN2_W bits), VPN2 (VPN2_W bits), region (top 2 bits).
- R5: An entry matches by address when its VPN2 and the request VPN2 are equal on every bit where the entry's page mask is 0.
- R6: Kind 2'b00 (all) marks exactly the entries whose index is strictly greater than the captured wired value, whatever their other fields hold.
- R7: Kind 2'b01 (address) marks every address-matching entry, whatever its global bit or MMID.
- R8: Kind 2'b10 (MMID) marks entries whose MMID equals the request MMID and whose global bit is 0.
- R9: Kind 2'b11 (address and MMID) marks address-matching entries that are global or whose MMID equals the request MMID.
- R10: Writing back changes only EHINV. Unmarked entries are rewritten bit for bit, and an EHINV already set stays set.
- R11: The request VPN2 is `req_va[VA_W-1:PAGE_SHIFT+1]`. The page-offset bits and the even/odd page bit of `req_va` have no effect.
- R12: With USE_REGION=1 an address match also requires the entry region to equal `req_region`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_kind | input | 2 | Invalidation kind |
| req_va | input | VA_W | Virtual address operand |
| req_region | input | 2 | Region tag of the address |
| req_mmid | input | MMID_W | Address-space identifier of the issuer |
| wired | input | IDX_W | Last wired index, spared by kind 0 |
| busy | output | 1 | Walk in progress |
| rd_en | output | 1 | Table read strobe |
| rd_addr | output | IDX_W | Table read index |
| rd_data | input | ENTRY_W | Entry returned one cycle after rd_addr |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | IDX_W | Table write index |
| wr_data | output | ENTRY_W | Entry written back |
| flush_done | output | 1 | One-cycle pulse after the walk |

## Verification
The bench builds the walker with its defaults: 16 entries, 32-bit addresses with 4 KiB pages, 16-bit MMID and region matching on. With 16 entries the wired boundary can be placed at index 0, at the last index and in between. The 19-bit VPN2 leaves room for page masks that hide anything from no bits to eight low bits. Entries are drawn from small pools of VPN2 and MMID values, so every kind produces both hits and misses, including global entries and region mismatches.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [1:0] {
    INV_ALL     = 2'b00,
    INV_VA      = 2'b01,
    INV_MMID    = 2'b10,
    INV_VA_MMID = 2'b11
  } inv_kind_e;

  // Decide whether an entry dies under a given kind.
  function automatic logic kind_hit(inv_kind_e kind, logic va_hit, logic mm_hit,
                                    logic glob, logic above_wired);
    logic r;
    case (kind)
      INV_ALL:  r = above_wired;
      INV_VA:   r = va_hit;
      INV_MMID: r = mm_hit && !glob;
      default:  r = va_hit && (glob || mm_hit);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int VPN2_W     = 19,
  parameter int MMID_W     = 16,
  parameter int USE_REGION = 1
) (
  input  inv_kind_e          kind,
  input  logic [VPN2_W-1:0]  e_vpn2,
  input  logic [VPN2_W-1:0]  e_pmask,
  input  logic [1:0]         e_region,
  input  logic [MMID_W-1:0]  e_mmid,
  input  logic               e_glob,
  input  logic [VPN2_W-1:0]  r_vpn2,
  input  logic [1:0]         r_region,
  input  logic [MMID_W-1:0]  r_mmid,
  input  logic               above_wired,
  output logic               hit
);

  logic region_ok;
  logic page_ok;
  logic va_hit;
  logic mm_hit;

  generate
    if (USE_REGION != 0) begin : g_region
      assign region_ok = (e_region == r_region);
    end else begin : g_noregion
      logic unused_region;
      assign unused_region = ^{e_region, r_region};
      assign region_ok = 1'b1;
    end
  endgenerate

  // Bits covered by the entry's page mask are don't-care in the compare.
  assign page_ok = ((e_vpn2 ^ r_vpn2) & ~e_pmask) == '0;
  assign va_hit  = page_ok && region_ok;
  assign mm_hit  = (e_mmid == r_mmid);
  assign hit     = kind_hit(kind, va_hit, mm_hit, e_glob, above_wired);

endmodule

// File: rtl/tlbinv_seq.sv
module tlbinv_seq #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             rd_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic             wb_q;
  logic [IDX_W-1:0] wb_idx_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      rd_idx_q <= '0;
      wb_q     <= 1'b0;
      wb_idx_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (start) begin
        rd_q     <= 1'b1;
        rd_idx_q <= '0;
      end else if (rd_q) begin
        if (rd_idx_q == LAST) rd_q <= 1'b0;
        else                  rd_idx_q <= rd_idx_q + IDX_W'(1);
      end
      wb_q     <= rd_q;
      wb_idx_q <= rd_idx_q;
      done_q   <= wb_q && (wb_idx_q == LAST);
    end
  end

  assign rd_en  = rd_q;
  assign rd_idx = rd_idx_q;
  assign wb_en  = wb_q;
  assign wb_idx = wb_idx_q;
  assign busy   = rd_q || wb_q;
  assign done   = done_q;

  assert_read_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx != LAST) |=> (rd_en && rd_idx == $past(rd_idx) + IDX_W'(1)));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_walk_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_idx == LAST) |=> (done && !wb_en));

endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MMID_W     = 16,
  parameter int PAY_W      = 8,
  parameter int USE_REGION = 1,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int VPN2_W    = VA_W - PAGE_SHIFT - 1,
  localparam int ENTRY_W   = PAY_W + 2 + MMID_W + 2 * VPN2_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [VA_W-1:0]    req_va,
  input  logic [1:0]         req_region,
  input  logic [MMID_W-1:0]  req_mmid,
  input  logic [IDX_W-1:0]   wired,
  output logic               busy,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_addr,
  input  logic [ENTRY_W-1:0] rd_data,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [ENTRY_W-1:0] wr_data,
  output logic               flush_done
);

  localparam int EH_LSB = PAY_W;
  localparam int G_LSB  = PAY_W + 1;
  localparam int MM_LSB = PAY_W + 2;
  localparam int PM_LSB = MM_LSB + MMID_W;
  localparam int VP_LSB = PM_LSB + VPN2_W;
  localparam int RG_LSB = VP_LSB + VPN2_W;
  localparam logic [ENTRY_W-1:0] EH_MASK = {{(ENTRY_W-1){1'b0}}, 1'b1} << EH_LSB;

  inv_kind_e         kind_q;
  logic [VPN2_W-1:0] vpn2_q;
  logic [1:0]        region_q;
  logic [MMID_W-1:0] mmid_q;
  logic [IDX_W-1:0]  wired_q;
  logic              accept;
  logic              busy_w;
  logic              wb_en;
  logic [IDX_W-1:0]  wb_idx;
  logic              hit;
  logic              unused_va_low;

  assign req_ready     = !busy_w;
  assign accept        = req_valid && !busy_w;
  assign unused_va_low = ^req_va[PAGE_SHIFT:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= INV_ALL;
      vpn2_q   <= '0;
      region_q <= '0;
      mmid_q   <= '0;
      wired_q  <= '0;
    end else if (accept) begin
      kind_q   <= inv_kind_e'(req_kind);
      vpn2_q   <= req_va[VA_W-1:PAGE_SHIFT+1];
      region_q <= req_region;
      mmid_q   <= req_mmid;
      wired_q  <= wired;
    end
  end

  tlbinv_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .rd_en  (rd_en),
    .rd_idx (rd_addr),
    .wb_en  (wb_en),
    .wb_idx (wb_idx),
    .busy   (busy_w),
    .done   (flush_done)
  );

  tlbinv_match #(
    .VPN2_W     (VPN2_W),
    .MMID_W     (MMID_W),
    .USE_REGION (USE_REGION)
  ) u_match (
    .kind        (kind_q),
    .e_vpn2      (rd_data[VP_LSB +: VPN2_W]),
    .e_pmask     (rd_data[PM_LSB +: VPN2_W]),
    .e_region    (rd_data[RG_LSB +: 2]),
    .e_mmid      (rd_data[MM_LSB +: MMID_W]),
    .e_glob      (rd_data[G_LSB]),
    .r_vpn2      (vpn2_q),
    .r_region    (region_q),
    .r_mmid      (mmid_q),
    .above_wired (wb_idx > wired_q),
    .hit         (hit)
  );

  assign busy    = busy_w;
  assign wr_en   = wb_en;
  assign wr_addr = wb_idx;
  assign wr_data = hit ? (rd_data | EH_MASK) : rd_data;

  assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(kind_q) && $stable(vpn2_q) && $stable(mmid_q) && $stable(wired_q)));

  assert_only_ehinv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (((wr_data ^ rd_data) & ~EH_MASK) == '0));

  assert_sticky_ehinv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[EH_LSB]) |-> wr_data[EH_LSB]);

  assert_wired_spared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind_q == INV_ALL && wr_addr <= wired_q) |-> (wr_data == rd_data));

  assert_global_spared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind_q == INV_MMID && rd_data[G_LSB]) |-> (wr_data == rd_data));

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> ($past(wr_en) && $past(wr_addr) == IDX_W'(ENTRIES - 1)));

endmodule

// File: tb/tlbinv_engine_tb.sv
module tlbinv_engine_tb;

  localparam int N     = 16;
  localparam int VA_W  = 32;
  localparam int PS    = 12;
  localparam int MW    = 16;
  localparam int PW    = 8;
  localparam int IW    = $clog2(N);
  localparam int V2    = VA_W - PS - 1;
  localparam int EW    = PW + 2 + MW + 2 * V2 + 2;
  localparam int EH    = PW;
  localparam int GB    = PW + 1;
  localparam int MM    = PW + 2;
  localparam int PM    = MM + MW;
  localparam int VP    = PM + V2;
  localparam int RG    = VP + V2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      req_kind = '0;
  logic [VA_W-1:0] req_va = '0;
  logic [1:0]      req_region = '0;
  logic [MW-1:0]   req_mmid = '0;
  logic [IW-1:0]   wired = '0;
  logic            busy, rd_en, wr_en, flush_done;
  logic [IW-1:0]   rd_addr, wr_addr;
  logic [EW-1:0]   rd_data, wr_data;

  tlbinv_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_va(req_va), .req_region(req_region),
    .req_mmid(req_mmid), .wired(wired), .busy(busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flush_done(flush_done)
  );

  // Table model: synchronous read, write port, and a bench load port.
  logic [EW-1:0] mem [N];
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [EW-1:0] ld_val = '0;

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
    if (ld_en) mem[ld_idx] <= ld_val;
  end

  int checks = 0;
  int fails  = 0;
  logic [V2-1:0] vpool [4];
  logic [MW-1:0] mpool [3];

  task automatic chk(input logic ok, input string tag, input logic [EW-1:0] act,
                     input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] model(input logic [EW-1:0] e, input int idx,
      input logic [1:0] k, input logic [VA_W-1:0] va, input logic [1:0] rg,
      input logic [MW-1:0] mm, input int wd);
    logic [V2-1:0] ev, pm, rv;
    logic amatch, mmatch, g, mark;
    ev = e[VP +: V2];
    pm = e[PM +: V2];
    rv = va[VA_W-1:PS+1];
    amatch = ((ev & ~pm) == (rv & ~pm)) && (e[RG +: 2] == rg);
    mmatch = (e[MM +: MW] == mm);
    g = e[GB];
    case (k)
      2'd0:    mark = (idx > wd);
      2'd1:    mark = amatch;
      2'd2:    mark = mmatch && !g;
      default: mark = amatch && (g || mmatch);
    endcase
    if (mark) e[EH] = 1'b1;
    return e;
  endfunction

  function automatic logic [EW-1:0] mk(input logic [1:0] rg, input logic [V2-1:0] v,
      input logic [V2-1:0] pm, input logic [MW-1:0] mm, input logic g,
      input logic eh, input logic [PW-1:0] pay);
    return {rg, v, pm, mm, g, eh, pay};
  endfunction

  task automatic load(input int i, input logic [EW-1:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IW'(i); ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic fill_random();
    for (int i = 0; i < N; i++) begin
      logic [V2-1:0] pm, v;
      case ($urandom % 4)
        0: pm = '0;
        1: pm = V2'(3);
        2: pm = V2'(8'hff);
        default: pm = V2'(1);
      endcase
      v = vpool[$urandom % 4] ^ (V2'($urandom) & pm);
      if ($urandom % 5 == 0) v = V2'($urandom);
      load(i, mk(($urandom % 4 == 0) ? 2'd1 : 2'd0, v, pm, mpool[$urandom % 3],
                 ($urandom % 4 == 0), ($urandom % 8 == 0), PW'($urandom)));
    end
  endtask

  // Issue one request, check timing and the resulting table.
  task automatic run_op(input logic [1:0] k, input logic [VA_W-1:0] va,
      input logic [1:0] rg, input logic [MW-1:0] mm, input int wd,
      input string tag, input logic intrude);
    logic [EW-1:0] expv [N];
    int cyc;
    for (int i = 0; i < N; i++) expv[i] = model(mem[i], i, k, va, rg, mm, wd);
    @(negedge clk);
    chk(req_ready, "R1 ready while idle", EW'(req_ready), EW'(1));
    req_valid = 1'b1; req_kind = k; req_va = va; req_region = rg;
    req_mmid = mm; wired = IW'(wd);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        req_valid = 1'b0;
        chk(busy && rd_en && rd_addr == '0 && !req_ready, "R2 walk start",
            EW'({busy, rd_en, rd_addr}), EW'({2'b11, IW'(0)}));
      end
      if (intrude && cyc == 3) begin
        req_valid = 1'b1; req_kind = 2'd0; wired = '0;
        req_va = ~va; req_mmid = ~mm;
      end
      if (intrude && cyc == 4) req_valid = 1'b0;
    end while (!flush_done && cyc < 200);
    chk(cyc == N + 2, "R2 R3 walk length", EW'(cyc), EW'(N + 2));
    chk(!busy, "R3 idle at done", EW'(busy), EW'(0));
    for (int i = 0; i < N; i++)
      chk(mem[i] === expv[i], $sformatf("%s entry %0d", tag, i), mem[i], expv[i]);
    @(negedge clk);
    chk(!flush_done, "R3 done single", EW'(flush_done), EW'(0));
    if (intrude) begin
      @(negedge clk);
      chk(!busy && !flush_done, "R1 start during busy ignored",
          EW'({busy, flush_done}), EW'(0));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [VA_W-1:0] va;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) vpool[i] = V2'($urandom);
    mpool[0] = 16'h1234; mpool[1] = 16'hbeef; mpool[2] = 16'h0042;
    repeat (3) @(negedge clk);
    chk(!busy && req_ready && !rd_en && !wr_en && !flush_done, "R1 R2 R3 reset state",
        EW'({busy, req_ready, rd_en, wr_en, flush_done}), EW'(5'b01000));
    rst_n = 1'b1;

    // Kind 0 at the wired boundaries (R6).
    fill_random();
    run_op(2'd0, '0, 2'd0, '0, 0, "R6 wired=0", 1'b0);
    fill_random();
    run_op(2'd0, '0, 2'd0, '0, N - 1, "R6 wired=last", 1'b0);
    fill_random();
    run_op(2'd0, '0, 2'd0, '0, 5, "R6 wired=5", 1'b0);

    // Crafted address cases: mask hides low bits, region differs (R5 R7 R12 R11 R4).
    fill_random();
    load(3, mk(2'd0, vpool[0] ^ V2'(3), V2'(3), mpool[1], 1'b0, 1'b0, 8'h5a));
    load(4, mk(2'd1, vpool[0], '0, mpool[1], 1'b1, 1'b0, 8'ha5));
    load(5, mk(2'd0, vpool[0] ^ V2'(4), V2'(3), mpool[1], 1'b1, 1'b1, 8'h3c));
    va = {vpool[0], 1'b1, PS'($urandom)};
    run_op(2'd1, va, 2'd0, mpool[0], 0, "R7 R5 R12 R11 crafted", 1'b0);
    chk(mem[3][EH] && !mem[4][EH] && mem[3][PW-1:0] == 8'h5a, "R5 R12 R10 entries 3/4",
        mem[3], mem[4]);

    // Kind 2 with a global entry carrying the requested MMID (R8).
    fill_random();
    load(2, mk(2'd0, vpool[1], '0, mpool[0], 1'b1, 1'b0, 8'h11));
    run_op(2'd2, '0, 2'd0, mpool[0], 0, "R8 mmid", 1'b0);
    chk(!mem[2][EH], "R8 global spared", mem[2], mk(2'd0, vpool[1], '0, mpool[0], 1'b1, 1'b0, 8'h11));

    // Kind 3 (R9).
    fill_random();
    run_op(2'd3, {vpool[2], 1'b0, PS'($urandom)}, 2'd0, mpool[1], 0, "R9 va+mmid", 1'b0);

    // Request raised during a walk is ignored (R1).
    fill_random();
    run_op(2'd2, '0, 2'd0, mpool[2], 0, "R1 R8 intrusion", 1'b1);

    // Random mix (R10 on every unmarked entry).
    for (int t = 0; t < 40; t++) begin
      fill_random();
      run_op(2'($urandom), {vpool[$urandom % 4], 1'($urandom), PS'($urandom)},
             ($urandom % 4 == 0) ? 2'd1 : 2'd0, mpool[$urandom % 3],
             int'($urandom % N), "R10 R6 R7 R8 R9 random", 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule